// File: doc/BRIEF.md
# Four-Channel Compare-Match System Timer

This block is a free-running system counter with four compare channels, accessed through a simple 32-bit register bus. The counter advances by one on each `tick_en` pulse. It runs as a 64-bit count or as a 32-bit count, depending on the `wide_mode` input. Software programs a 32-bit match value for each channel and turns compare on for each channel. When the low 32 bits of the count equal an enabled channel's match value, that channel's status bit is set. Its level interrupt line then stays high until software clears it.

Writes to the match values and to the compare enables do not take effect at once. Each one passes through a fixed delay of five clock cycles. While a write is waiting, software can see a per-channel busy flag in the control word. Status bits are write-one-to-clear. A single write to the control word can clear one channel's status and set the compare enables at the same time. Reading the low count word captures the high word into a shadow, so a following read of the high word gives a coherent 64-bit value.

Top module: `sys_match_timer`

## Requirements
- R1: After reset, the count equals the `INIT_COUNT` parameter. All match values, compare enables, status bits, busy flags and `irq` lines are zero.
- R2: The count increases by exactly one on each cycle with `tick_en` high, and holds its value otherwise.
- R3: With `wide_mode`=1 the count is 64 bits and carries from the low word into the high word. With `wide_mode`=0 the high word is forced to zero, reads of offset 0x08 return zero, and the low word wraps from 0xFFFFFFFF to 0.
- R4: A read of offset 0x04 returns the low word and captures the high word. A later read of 0x08 in 64-bit mode returns that captured value.
- R5: A write to a match register changes its value 5 clock edges after the write edge. The match registers are at 0x0C + 4·n for channel n. Bit 12+n of the control word (offset 0x00) reads 1 during the five cycles after the write and 0 from then on. A read of a match register returns the value currently in effect.
- R6: A control-word write loads compare enable n from data bit 4+n, and the enable changes 5 edges later. Bits 11:8 all read 1 during the wait. Bits 7:4 read the enables in effect.
- R7: When compare enable n is in effect and the low count word equals match value n, status bit n (control bit n) is set on the next edge. `irq[n]` equals status bit n.
- R8: A control-word write with data bit n (n in 0..3) equal to 1 clears status bit n. Status bits whose data bit is 0 are left unchanged. A clear and an enable update may share one write.
- R9: After a channel matches, it does not match again until its status is cleared or a new enable value takes effect. A clear written while the count still equals the match value sets the status to 0 for one cycle, and the status then sets again.
- R10: Control-word bits 31:16 read zero. Offsets outside the map read zero, and `bus_rdata` is zero when `bus_rd` is low.
- R11: A second write to the same register while it is still waiting restarts the 5-cycle wait. Only the latest value takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count advance strobe |
| wide_mode | input | 1 | 1: 64-bit count, 0: 32-bit count |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 4 | Per-channel level interrupt |

## Verification
The hardest case to reach is the re-arm race. A clear lands while the count still sits on the match value, and the one-cycle drop in status only shows if the counter is frozen exactly there. The bench stops `tick_en`, loads the current count as a match value, waits out the synchronisation delay, and then issues the clear, checking `irq` on the two following cycles. Wrap-around and carry are reached in a few hundred cycles by starting the count just below a 32-bit boundary through `INIT_COUNT`. A reference model is compared with the design on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 4;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_LO   = 8'h04;
  localparam logic [7:0] OFS_HI   = 8'h08;
  localparam logic [7:0] OFS_M0   = 8'h0C;

  // next count value for one clock edge
  function automatic logic [63:0] count_next(input logic [63:0] c, input logic tick,
                                             input logic wide);
    logic [63:0] n;
    n = tick ? c + 64'd1 : c;
    if (!wide) n = {32'h0, tick ? c[31:0] + 32'd1 : c[31:0]};
    return n;
  endfunction

  function automatic logic is_match_ofs(input logic [7:0] a);
    return (a >= OFS_M0) && (a < OFS_M0 + 8'(4 * NCH)) && (a[1:0] == 2'b00);
  endfunction

  function automatic int match_index(input logic [7:0] a);
    return int'((a - OFS_M0) >> 2);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter import tmr_pkg::*; #(
  parameter logic [63:0] INIT_COUNT = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wide,
  input  logic        cap_hi,
  output logic [63:0] cnt,
  output logic [31:0] hi_shadow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= INIT_COUNT;
      hi_shadow <= 32'h0;
    end else begin
      cnt <= count_next(cnt, tick, wide);
      if (cap_hi) hi_shadow <= cnt[63:32];
    end
  end
endmodule

// File: rtl/tmr_sync_reg.sv
module tmr_sync_reg #(
  parameter int W   = 32,
  parameter int DLY = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cur,
  output logic         busy,
  output logic         apply_now
);
  localparam int CW = $clog2(DLY + 1);
  logic [W-1:0]  hold_q;
  logic [CW-1:0] left_q;

  assign apply_now = busy && (left_q == '0) && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      hold_q <= '0;
      left_q <= '0;
      busy   <= 1'b0;
    end else if (wr_en) begin
      hold_q <= wr_val;
      left_q <= CW'(DLY - 1);
      busy   <= 1'b1;
    end else if (apply_now) begin
      cur  <= hold_q;
      busy <= 1'b0;
    end else if (busy) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [31:0] match_val,
  input  logic [31:0] cnt_lo,
  input  logic        clr,
  input  logic        rearm,
  output logic        status,
  output logic        hit
);
  logic armed_q;

  assign hit = en && armed_q && (cnt_lo == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (hit)      status <= 1'b1;
      else if (clr) status <= 1'b0;
      if (hit)                armed_q <= 1'b0;
      else if (clr || rearm)  armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sys_match_timer.sv
module sys_match_timer import tmr_pkg::*; #(
  parameter int          AW         = 5,
  parameter int          SYNC_DLY   = 5,
  parameter logic [63:0] INIT_COUNT = 64'h0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           wide_mode,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] irq
);
  logic [7:0]     ofs;
  logic           ctrl_wr;
  logic           lo_rd;
  logic [63:0]    cnt_q;
  logic [31:0]    hi_shadow;
  logic [NCH-1:0] en_w, esync_w, eapply_w, msync_w, status_w, hit_w;
  logic [31:0]    mval_w [NCH];

  assign ofs     = 8'(bus_addr);
  assign ctrl_wr = bus_wr && (ofs == OFS_CTRL);
  assign lo_rd   = bus_rd && (ofs == OFS_LO);

  tmr_counter #(.INIT_COUNT(INIT_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .wide(wide_mode),
    .cap_hi(lo_rd), .cnt(cnt_q), .hi_shadow(hi_shadow)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic mwr;
    logic mapply;
    assign mwr = bus_wr && is_match_ofs(ofs) && (match_index(ofs) == ch);

    tmr_sync_reg #(.W(32), .DLY(SYNC_DLY)) u_msync (
      .clk(clk), .rst_n(rst_n), .wr_en(mwr), .wr_val(bus_wdata),
      .cur(mval_w[ch]), .busy(msync_w[ch]), .apply_now(mapply)
    );

    tmr_sync_reg #(.W(1), .DLY(SYNC_DLY)) u_esync (
      .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wr_val(bus_wdata[4+ch]),
      .cur(en_w[ch]), .busy(esync_w[ch]), .apply_now(eapply_w[ch])
    );

    tmr_channel u_chan (
      .clk(clk), .rst_n(rst_n), .en(en_w[ch]), .match_val(mval_w[ch]),
      .cnt_lo(cnt_q[31:0]), .clr(ctrl_wr && bus_wdata[ch]),
      .rearm(eapply_w[ch]), .status(status_w[ch]), .hit(hit_w[ch])
    );
  end

  assign irq = status_w;

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_rd) begin
      if (ofs == OFS_CTRL)       bus_rdata = {16'h0, msync_w, esync_w, en_w, status_w};
      else if (ofs == OFS_LO)    bus_rdata = cnt_q[31:0];
      else if (ofs == OFS_HI)    bus_rdata = wide_mode ? hi_shadow : 32'h0;
      else if (is_match_ofs(ofs)) bus_rdata = mval_w[match_index(ofs)];
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int AW = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wide_mode,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic [3:0]  irq,
  input logic [63:0] cnt,
  input logic [3:0]  hit,
  input logic [3:0]  msync
);
  AST_STEP_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && wide_mode |=> cnt == $past(cnt) + 64'd1); // R2
  AST_HOLD_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && wide_mode |=> cnt == $past(cnt)); // R2
  AST_HI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |=> cnt[63:32] == 32'h0); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (8'(bus_addr) == 8'h00) |-> bus_rdata[31:16] == 16'h0); // R10
  AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (8'(bus_addr) == 8'h00) |-> bus_rdata[3:0] == irq); // R7
  AST_SYNC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (8'(bus_addr) == 8'h0C) |=> msync[0]); // R5
  for (genvar i = 0; i < 4; i++) begin : g_irq
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(hit[i])); // R7
  end
endmodule

bind sys_match_timer tmr_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wide_mode(wide_mode),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq(irq), .cnt(cnt_q), .hit(hit_w), .msync(msync_w)
);

// File: tb/sim_sys_match_timer.sv
module sim_sys_match_timer;
  localparam logic [63:0] INIT = 64'h0000_0001_FFFF_FF00;
  logic clk = 1'b0;
  logic rst_n, tick_en, wide_mode, bus_wr, bus_rd;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  irq;
  int total = 0, bad = 0;
  bit finished = 0;

  sys_match_timer #(.AW(5), .SYNC_DLY(5), .INIT_COUNT(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wide_mode(wide_mode),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  // reference model
  logic [63:0] m_cnt;
  logic [31:0] m_sh;
  logic [31:0] m_mat [4];
  logic [31:0] m_mpend [4];
  int          m_mdly [4];
  int          m_edly [4];
  logic [3:0]  m_en, m_epend, m_st, m_arm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = INIT; m_sh = 0; m_en = 0; m_epend = 0; m_st = 0; m_arm = 4'hF;
      for (int i = 0; i < 4; i++) begin m_mat[i] = 0; m_mpend[i] = 0; m_mdly[i] = 0; m_edly[i] = 0; end
    end else begin
      logic [3:0] hit, clr, rearm;
      logic cw;
      cw = bus_wr && bus_addr == 5'h00;
      for (int i = 0; i < 4; i++) begin
        hit[i] = m_en[i] && m_arm[i] && (m_cnt[31:0] == m_mat[i]);
        clr[i] = cw && bus_wdata[i];
        rearm[i] = 1'b0;
      end
      if (bus_rd && bus_addr == 5'h04) m_sh = m_cnt[63:32];
      for (int i = 0; i < 4; i++) begin
        if (cw) begin m_edly[i] = 5; m_epend[i] = bus_wdata[4+i]; end
        else if (m_edly[i] == 1) begin m_en[i] = m_epend[i]; m_edly[i] = 0; rearm[i] = 1'b1; end
        else if (m_edly[i] > 0) m_edly[i]--;
        if (bus_wr && bus_addr == 5'(12 + 4*i)) begin m_mdly[i] = 5; m_mpend[i] = bus_wdata; end
        else if (m_mdly[i] == 1) begin m_mat[i] = m_mpend[i]; m_mdly[i] = 0; end
        else if (m_mdly[i] > 0) m_mdly[i]--;
        if (hit[i]) begin m_st[i] = 1; m_arm[i] = 0; end
        else begin
          if (clr[i]) m_st[i] = 0;
          if (clr[i] || rearm[i]) m_arm[i] = 1;
        end
      end
      if (tick_en) m_cnt = wide_mode ? m_cnt + 1 : {32'h0, m_cnt[31:0] + 32'd1};
      else if (!wide_mode) m_cnt = {32'h0, m_cnt[31:0]};
    end
  end

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    logic [3:0] ms, es;
    for (int i = 0; i < 4; i++) begin ms[i] = m_mdly[i] > 0; es[i] = m_edly[i] > 0; end
    case (a)
      5'h00: return {16'h0, ms, es, m_en, m_st};
      5'h04: return m_cnt[31:0];
      5'h08: return wide_mode ? m_sh : 32'h0;
      5'h0C: return m_mat[0];
      5'h10: return m_mat[1];
      5'h14: return m_mat[2];
      5'h18: return m_mat[3];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  // every-cycle comparison of the interrupt lines (R7)
  always @(negedge clk) if (rst_n === 1'b1 && !finished)
    chk(irq === m_st, "R7 irq vs model", 64'(irq), 64'(m_st));

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag, output logic [31:0] d);
    logic [31:0] e;
    bus_rd = 1; bus_addr = a;
    #1;
    e = exp_rd(a);
    d = bus_rdata;
    chk(d === e, tag, 64'(d), 64'(e));
    @(negedge clk);
    bus_rd = 0;
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] lo;
    rst_n = 0; tick_en = 0; wide_mode = 1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(irq === 4'h0, "R1 irq", 64'(irq), 0);
    rd(5'h00, "R1 ctrl", d); chk(d === 32'h0, "R1 ctrl zero", 64'(d), 0);
    rd(5'h0C, "R1 match0", d); chk(d === 32'h0, "R1 match0 zero", 64'(d), 0);
    rd(5'h04, "R1 lo", d); chk(d === 32'hFFFF_FF00, "R1 lo init", 64'(d), 64'hFFFFFF00);
    rd(5'h08, "R4 hi shadow", d); chk(d === 32'h1, "R4 hi init", 64'(d), 1);
    // R2 hold without tick
    repeat (4) @(negedge clk);
    rd(5'h04, "R2 hold", d); chk(d === 32'hFFFF_FF00, "R2 no tick", 64'(d), 64'hFFFFFF00);
    // R3 carry in 64-bit mode
    tick_en = 1;
    repeat (300) @(negedge clk);
    rd(5'h04, "R2 lo ticking", d);
    rd(5'h08, "R3 hi carry", d); chk(d === 32'h2, "R3 carry", 64'(d), 2);
    repeat (10) @(negedge clk);
    rd(5'h08, "R4 shadow held", d);
    // R3 32-bit mode
    wide_mode = 0;
    repeat (2) @(negedge clk);
    rd(5'h04, "R3 lo narrow", d);
    rd(5'h08, "R3 hi narrow", d); chk(d === 32'h0, "R3 hi zero", 64'(d), 0);
    // R5 match sync
    lo = m_cnt[31:0] + 32'd200;
    wr(5'h0C, lo);
    for (int i = 0; i < 5; i++) begin
      rd(5'h00, "R5 sync pending", d); chk(d[12] === 1'b1, "R5 flag high", 64'(d[12]), 1);
    end
    rd(5'h00, "R5 sync done", d); chk(d[12] === 1'b0, "R5 flag low", 64'(d[12]), 0);
    rd(5'h0C, "R5 applied", d); chk(d === lo, "R5 value", 64'(d), 64'(lo));
    // R6 enable sync
    wr(5'h00, 32'h10);
    rd(5'h00, "R6 esync", d); chk(d[11:4] === 8'hF0, "R6 flags", 64'(d[11:4]), 64'hF0);
    repeat (5) @(negedge clk);
    rd(5'h00, "R6 en applied", d); chk(d[11:4] === 8'h01, "R6 en", 64'(d[11:4]), 1);
    repeat (250) @(negedge clk);
    chk(irq === 4'b0001, "R7 match ch0", 64'(irq), 1);
    // R11 rewrite during wait
    wr(5'h14, 32'hAAAA_0001);
    repeat (2) @(negedge clk);
    wr(5'h14, 32'h5555_0002);
    for (int i = 0; i < 5; i++) begin
      rd(5'h14, "R11 old kept", d); chk(d === 32'h0, "R11 pending", 64'(d), 0);
    end
    rd(5'h14, "R11 latest", d); chk(d === 32'h5555_0002, "R11 value", 64'(d), 64'h55550002);
    // frozen count on channel 1
    tick_en = 0;
    @(negedge clk);
    lo = m_cnt[31:0];
    wr(5'h10, lo);
    wr(5'h00, 32'h30);
    repeat (7) @(negedge clk);
    chk(irq === 4'b0011, "R7 match ch1", 64'(irq), 3);
    // R8 clear ch0 only, same write keeps enables
    wr(5'h00, 32'h31);
    chk(irq === 4'b0010, "R8 clear one", 64'(irq), 2);
    repeat (6) @(negedge clk);
    // R9 clear while still equal
    wr(5'h00, 32'h32);
    chk(irq[1] === 1'b0, "R9 cleared", 64'(irq[1]), 0);
    @(negedge clk);
    chk(irq[1] === 1'b1, "R9 rematch", 64'(irq[1]), 1);
    // R10 reserved and unmapped
    rd(5'h1C, "R10 unmapped", d); chk(d === 32'h0, "R10 zero", 64'(d), 0);
    rd(5'h00, "R10 ctrl", d); chk(d[31:16] === 16'h0, "R10 rsvd", 64'(d[31:16]), 0);
    #1 chk(bus_rdata === 32'h0, "R10 idle", 64'(bus_rdata), 0);
    // R3 wrap in 32-bit mode
    rst_n = 0; @(negedge clk); rst_n = 1; tick_en = 1;
    repeat (300) @(negedge clk);
    rd(5'h04, "R3 wrap", d); chk(d < 32'h200, "R3 wrapped", 64'(d), 64'd300);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule